// File: doc/BRIEF.md
# 65xx Bus Glue: Address Decoder and Keyboard Latch

This block is the glue logic between a 65xx processor bus and its memory and peripherals. It decodes the 16-bit address into four mutually exclusive selects: general RAM, the keyboard data port, the key-acknowledge port and general I/O. It also produces bus read and write strobes that are qualified by the PHI2 clock phase. It holds the most recent keyboard code together with a key-waiting flag, and returns them as one byte for keyboard reads.

The two upper RAM areas hold the shadowed firmware image. They are loaded while the init-mode input is high. Once init mode is low, the block refuses writes into them. Selects and strobes are combinational from the bus inputs. The keyboard latch is registered on the fabric clock `clk`, and PHI2 is sampled as a level on that clock.

Top module: `bus_glue_decoder`

## Requirements
- R1: Addresses 0x0000 to 0xBFFF assert `ram_sel` only.
- R2: Addresses 0x C000 to 0xC00F assert `kbd_sel` only. `kbd_data` always presents the key-waiting flag on bit 7 and the 7-bit key code on bits 6..0.
- R3: When a `clk` edge sees `phi2` high with the address in 0xC010 to 0xC01F, the key-waiting flag is cleared at that edge, whatever the level of `rw`. That range asserts `ack_sel` only. With `phi2` low, the range does not change the flag.
- R4: Addresses 0xC020 to 0xC0FF assert `io_sel` only.
- R5: Addresses 0xC100 to 0xFFFF assert `ram_sel`. While `init_mode` is low, `ram_we` stays low for these addresses.
- R6: `mem_rd` equals `rw` high AND `phi2` high. `mem_wr` equals `rw` low AND `phi2` high. The two are never high together.
- R7: A `clk` edge with `key_stb` high loads `key_code` and sets the flag. If a clear happens at the same edge, the set wins.
- R8: While `init_mode` is high, `ram_we` follows `mem_wr` for every RAM address. Below 0xC000 it does so regardless of `init_mode`.
- R9: At most one of the four selects is high for any address.
- R10: Synchronous active-high `rst` clears the flag and the code, so `kbd_data` reads 0x00. Without a strobe or a clear, `kbd_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock for the keyboard latch |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 16 | CPU address bus |
| rw | input | 1 | CPU read/write line, high for read |
| phi2 | input | 1 | CPU phase-2 clock level |
| init_mode | input | 1 | High while the firmware image is being loaded |
| key_stb | input | 1 | One-cycle pulse marking a new key code |
| key_code | input | 7 | Key code from the keyboard front end |
| ram_sel | output | 1 | RAM chip select |
| kbd_sel | output | 1 | Keyboard data port select |
| ack_sel | output | 1 | Key-acknowledge port select |
| io_sel | output | 1 | General I/O select |
| mem_rd | output | 1 | PHI2-qualified read enable |
| mem_wr | output | 1 | PHI2-qualified write enable |
| ram_we | output | 1 | RAM write enable after write protection |
| kbd_data | output | 8 | Flag on bit 7, key code on bits 6..0 |

## Verification
The checker tests several properties on every cycle:
- the selects are exclusive;
- the read and write strobes never overlap, and neither appears with PHI2 low;
- the protected area never sees `ram_we` outside init mode;
- a strobe always leaves the new code and a set flag;
- an acknowledge with no strobe always leaves the flag clear;
- the latch holds when neither event occurs.

Some behaviour can only be shown by the bench's scenarios. These are the exact range boundaries, such as 0xBFFF against 0xC000 and 0xC0FF against 0xC100, and the priority between a strobe and an acknowledge at the same edge. The same applies to an acknowledge with PHI2 low leaving the flag untouched, and to a keyboard read not clearing the flag.

// File: rtl/glue_pkg.sv
package glue_pkg;
  typedef enum logic [2:0] {
    REG_RAM_LOW,
    REG_KBD,
    REG_ACK,
    REG_IO,
    REG_RAM_PROT
  } region_e;
endpackage

// File: rtl/glue_addr_decode.sv
module glue_addr_decode
  import glue_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] KBD_BASE  = 16'hC000,
  parameter logic [ADDR_W-1:0] ACK_BASE  = 16'hC010,
  parameter logic [ADDR_W-1:0] IO_BASE   = 16'hC020,
  parameter logic [ADDR_W-1:0] PROT_BASE = 16'hC100
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output logic              ram_sel,
  output logic              kbd_sel,
  output logic              ack_sel,
  output logic              io_sel,
  output logic              prot_hit
);
  always_comb begin
    if (addr < KBD_BASE)       region = REG_RAM_LOW;
    else if (addr < ACK_BASE)  region = REG_KBD;
    else if (addr < IO_BASE)   region = REG_ACK;
    else if (addr < PROT_BASE) region = REG_IO;
    else                       region = REG_RAM_PROT;
  end

  assign ram_sel  = (region == REG_RAM_LOW) || (region == REG_RAM_PROT);
  assign kbd_sel  = (region == REG_KBD);
  assign ack_sel  = (region == REG_ACK);
  assign io_sel   = (region == REG_IO);
  assign prot_hit = (region == REG_RAM_PROT);
endmodule

// File: rtl/glue_key_latch.sv
module glue_key_latch #(
  parameter int CODE_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              key_stb,
  input  logic [CODE_W-1:0] key_code,
  input  logic              ack_hit,
  output logic [CODE_W:0]   kbd_data
);
  logic              flag_q;
  logic [CODE_W-1:0] code_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      code_q <= '0;
    end else begin
      if (key_stb) begin
        flag_q <= 1'b1;
        code_q <= key_code;
      end else if (ack_hit) begin
        flag_q <= 1'b0;
      end
    end
  end

  assign kbd_data = {flag_q, code_q};
endmodule

// File: rtl/glue_strobe_gen.sv
module glue_strobe_gen (
  input  logic rw,
  input  logic phi2,
  input  logic init_mode,
  input  logic ram_sel,
  input  logic prot_hit,
  output logic mem_rd,
  output logic mem_wr,
  output logic ram_we
);
  logic write_ok;

  assign mem_rd   = rw & phi2;
  assign mem_wr   = ~rw & phi2;
  assign write_ok = init_mode | ~prot_hit;
  assign ram_we   = mem_wr & ram_sel & write_ok;
endmodule

// File: rtl/bus_glue_decoder.sv
module bus_glue_decoder
  import glue_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CODE_W = 7,
  parameter logic [ADDR_W-1:0] KBD_BASE  = 16'hC000,
  parameter logic [ADDR_W-1:0] ACK_BASE  = 16'hC010,
  parameter logic [ADDR_W-1:0] IO_BASE   = 16'hC020,
  parameter logic [ADDR_W-1:0] PROT_BASE = 16'hC100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rw,
  input  logic              phi2,
  input  logic              init_mode,
  input  logic              key_stb,
  input  logic [CODE_W-1:0] key_code,
  output logic              ram_sel,
  output logic              kbd_sel,
  output logic              ack_sel,
  output logic              io_sel,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic              ram_we,
  output logic [CODE_W:0]   kbd_data
);
  region_e region;
  logic    prot_hit;
  logic    ack_hit;

  glue_addr_decode #(
    .ADDR_W(ADDR_W), .KBD_BASE(KBD_BASE), .ACK_BASE(ACK_BASE),
    .IO_BASE(IO_BASE), .PROT_BASE(PROT_BASE)
  ) u_dec (
    .addr(addr), .region(region), .ram_sel(ram_sel), .kbd_sel(kbd_sel),
    .ack_sel(ack_sel), .io_sel(io_sel), .prot_hit(prot_hit)
  );

  assign ack_hit = ack_sel & phi2;

  glue_key_latch #(.CODE_W(CODE_W)) u_key (
    .clk(clk), .rst(rst), .key_stb(key_stb), .key_code(key_code),
    .ack_hit(ack_hit), .kbd_data(kbd_data)
  );

  glue_strobe_gen u_stb (
    .rw(rw), .phi2(phi2), .init_mode(init_mode), .ram_sel(ram_sel),
    .prot_hit(prot_hit), .mem_rd(mem_rd), .mem_wr(mem_wr), .ram_we(ram_we)
  );
endmodule

// File: rtl/bus_glue_checker.sv
module bus_glue_checker #(
  parameter int ADDR_W = 16,
  parameter int CODE_W = 7,
  parameter logic [ADDR_W-1:0] ACK_BASE  = 16'hC010,
  parameter logic [ADDR_W-1:0] IO_BASE   = 16'hC020,
  parameter logic [ADDR_W-1:0] PROT_BASE = 16'hC100
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic              phi2,
  input logic              init_mode,
  input logic              key_stb,
  input logic [CODE_W-1:0] key_code,
  input logic              ram_sel,
  input logic              kbd_sel,
  input logic              ack_sel,
  input logic              io_sel,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic              ram_we,
  input logic [CODE_W:0]   kbd_data
);
  logic ack_evt;
  assign ack_evt = phi2 && (addr >= ACK_BASE) && (addr < IO_BASE);

  assert_one_select_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ram_sel, kbd_sel, ack_sel, io_sel}));

  assert_strobes_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr) && ((mem_rd || mem_wr) -> phi2));

  assert_protect_locked_R5: assert property (@(posedge clk) disable iff (rst)
    (!init_mode && addr >= PROT_BASE) |-> !ram_we);

  assert_strobe_loads_R7: assert property (@(posedge clk) disable iff (rst)
    key_stb |=> (kbd_data == {1'b1, $past(key_code)}));

  assert_ack_clears_R3: assert property (@(posedge clk) disable iff (rst)
    (ack_evt && !key_stb) |=> !kbd_data[CODE_W]);

  assert_latch_holds_R10: assert property (@(posedge clk) disable iff (rst)
    (!ack_evt && !key_stb) |=> $stable(kbd_data));
endmodule

bind bus_glue_decoder bus_glue_checker #(
  .ADDR_W(ADDR_W), .CODE_W(CODE_W), .ACK_BASE(ACK_BASE),
  .IO_BASE(IO_BASE), .PROT_BASE(PROT_BASE)
) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .phi2(phi2), .init_mode(init_mode),
  .key_stb(key_stb), .key_code(key_code), .ram_sel(ram_sel),
  .kbd_sel(kbd_sel), .ack_sel(ack_sel), .io_sel(io_sel), .mem_rd(mem_rd),
  .mem_wr(mem_wr), .ram_we(ram_we), .kbd_data(kbd_data)
);

// File: tb/tb_bus_glue_decoder.sv
`timescale 1ns/1ps
module tb_bus_glue_decoder;
  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] addr;
  logic        rw, phi2, init_mode, key_stb;
  logic [6:0]  key_code;
  logic        ram_sel, kbd_sel, ack_sel, io_sel, mem_rd, mem_wr, ram_we;
  logic [7:0]  kbd_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bus_glue_decoder dut (
    .clk(clk), .rst(rst), .addr(addr), .rw(rw), .phi2(phi2),
    .init_mode(init_mode), .key_stb(key_stb), .key_code(key_code),
    .ram_sel(ram_sel), .kbd_sel(kbd_sel), .ack_sel(ack_sel), .io_sel(io_sel),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .ram_we(ram_we), .kbd_data(kbd_data)
  );

  // {addr, rw, phi2, init_mode, expected {ram,kbd,ack,io,rd,wr,we}}
  localparam logic [25:0] VEC [14] = '{
    {16'h0000, 1'b0, 1'b1, 1'b0, 7'b1000011},  // R1 R8
    {16'hBFFF, 1'b1, 1'b1, 1'b0, 7'b1000100},  // R1 R6
    {16'hC000, 1'b1, 1'b1, 1'b0, 7'b0100100},  // R2
    {16'hC00F, 1'b0, 1'b1, 1'b0, 7'b0100010},  // R2
    {16'hC010, 1'b1, 1'b0, 1'b0, 7'b0010000},  // R3 R6
    {16'hC01F, 1'b1, 1'b1, 1'b0, 7'b0010100},  // R3
    {16'hC020, 1'b0, 1'b1, 1'b0, 7'b0001010},  // R4
    {16'hC0FF, 1'b1, 1'b1, 1'b0, 7'b0001100},  // R4
    {16'hC100, 1'b0, 1'b1, 1'b0, 7'b1000010},  // R5
    {16'hCFFF, 1'b0, 1'b1, 1'b1, 7'b1000011},  // R8
    {16'hD000, 1'b0, 1'b1, 1'b0, 7'b1000010},  // R5
    {16'hFFFF, 1'b0, 1'b1, 1'b1, 7'b1000011},  // R8
    {16'h8000, 1'b0, 1'b0, 1'b0, 7'b1000000},  // R6
    {16'hBFFF, 1'b0, 1'b1, 1'b0, 7'b1000011}   // R8
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    addr = 16'h0000; rw = 1'b1; phi2 = 1'b0; key_stb = 1'b0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; init_mode = 1'b0; key_code = 7'h00; idle();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R10 reset", kbd_data, 8'h00);

    for (int i = 0; i < 14; i++) begin
      @(negedge clk);
      {addr, rw, phi2, init_mode} = VEC[i][25:7];
      #1;
      check($sformatf("R9 vec%0d", i),
            {1'b0, ram_sel, kbd_sel, ack_sel, io_sel, mem_rd, mem_wr, ram_we},
            {1'b0, VEC[i][6:0]});
    end
    @(negedge clk); idle(); init_mode = 1'b0;

    // R7 strobe loads code and sets flag
    key_stb = 1'b1; key_code = 7'h41;
    @(negedge clk); key_stb = 1'b0;
    check("R7 load", kbd_data, 8'hC1);

    // R2 keyboard read does not clear
    addr = 16'hC000; rw = 1'b1; phi2 = 1'b1;
    @(negedge clk); idle();
    check("R2 read keeps flag", kbd_data, 8'hC1);

    // R3 ack with phi2 low ignored
    addr = 16'hC015; phi2 = 1'b0;
    @(negedge clk); idle();
    check("R3 phi2 low no clear", kbd_data, 8'hC1);

    // R3 ack write with phi2 high clears flag
    addr = 16'hC015; rw = 1'b0; phi2 = 1'b1;
    @(negedge clk); idle();
    check("R3 clear", kbd_data, 8'h41);

    // R10 hold
    @(negedge clk);
    check("R10 hold", kbd_data, 8'h41);

    // R7 set wins over simultaneous ack
    addr = 16'hC010; phi2 = 1'b1; key_stb = 1'b1; key_code = 7'h2A;
    @(negedge clk); idle();
    check("R7 set wins", kbd_data, 8'hAA);

    // R10 reset clears latch
    rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R10 reset again", kbd_data, 8'h00);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule